// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

This block gives software control of sixteen general-purpose pins through a small register interface. The interface has a byte address, a write strobe, 32-bit write data and combinational read data. Each pin has an output value and a direction bit, and its input is sampled through a two-flop synchronizer. The synchronized value is readable and also feeds interrupt detection.

Every line has its own 3-bit detection style. Two styles are level-sensitive (high or low) and three are edge-sensitive (rising, falling, or any change). A detected condition latches a sticky status bit, which software clears by writing a one to it. Lines 0 to 12 each drive an active-high interrupt output that follows the line's status bit. A clock-control word and a debounce-select word are kept only as storage that software can read and write.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output word (0x00) reads 0, the direction word (0x04) reads 0xFFFF (all inputs), status (0x0C), both style words (0x10, 0x14), clock control (0x18) and debounce select (0x1C) read 0, `pin_oe` is 0 and `irq_o` is 0.
- R2: Words at 0x00, 0x04, 0x18 and 0x1C read back what was written; 0x00 and 0x04 keep only their low 16 bits. `pin_out` equals word 0x00. `pin_oe[n]` is 1 exactly when bit n of word 0x04 is 0 (0 = drive, 1 = input).
- R3: Word 0x08 returns `pin_in` delayed by two clock edges through the synchronizer. Writes to 0x08 are ignored.
- R4: Line n uses bits [3k+2:3k] of word 0x10 when n<8 (k=n) or of word 0x14 when n>=8 (k=n-8). Bits [31:24] of both words read 0.
- R5: Style 0 sets status while the synchronized input is 1, and style 1 sets it while the input is 0. The bit is set again on every clock while the condition holds, so a clear takes effect only after the pin goes inactive.
- R6: Style 2 sets status on a 0-to-1 change of the synchronized input, style 3 on a 1-to-0 change, and style 4 on either change. A change is found by comparing the input with its value one clock earlier. The status bit stays set after the pin settles.
- R7: Styles 5, 6 and 7 never set status, whatever the pin does.
- R8: Writing 1 to bit n of 0x0C clears status bit n. Writing 0 leaves it unchanged.
- R9: When a detection and a clear hit the same status bit in one cycle, the bit stays 1.
- R10: `irq_o[n]` equals status bit n for lines 0 to 12. Lines 13 to 15 drive no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address of the register word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 16 | Pin input levels (asynchronous) |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin drive enables, 1 = drive |
| irq_o | output | 13 | Per-line interrupt outputs for lines 0 to 12 |

## Verification
Random register traffic, with readback masked to each word's width, checks the storage registers, the packing of the style fields and the pin mapping. Random pin words check the synchronizer latency and that the input word cannot be written.

Directed cases drive each style in both directions on chosen lines. This separates rising from falling from any-change detection, and level from edge, on lines in both style words. The reserved codes are driven through both transitions to show they stay quiet. Holding a level condition while clearing shows the set-wins rule, and a write of zero separates a clear from a no-op. Line 14 shows that a line above 12 raises status but no interrupt output.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NLINES = 16,
  parameter int NIRQ   = 13,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq_o
);
  localparam int PERWORD = 8;
  localparam int SW      = 3;
  localparam int IW      = AW - 2;

  localparam logic [IW-1:0] A_OUT = IW'(0);
  localparam logic [IW-1:0] A_DIR = IW'(1);
  localparam logic [IW-1:0] A_IN  = IW'(2);
  localparam logic [IW-1:0] A_ST  = IW'(3);
  localparam logic [IW-1:0] A_SL  = IW'(4);
  localparam logic [IW-1:0] A_SH  = IW'(5);
  localparam logic [IW-1:0] A_CK  = IW'(6);
  localparam logic [IW-1:0] A_DB  = IW'(7);

  logic [NLINES-1:0] out_q, dir_q, sy1_q, sy2_q, prv_q, stat_q;
  logic [NLINES-1:0] hit, clr;
  logic [SW-1:0]     style_q [NLINES];
  logic [31:0]       clk_q, dbs_q;
  logic [IW-1:0]     idx;
  logic              aligned;

  assign idx     = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq_o   = stat_q[NIRQ-1:0];
  assign clr     = (wr_en && aligned && idx == A_ST) ? wr_data[NLINES-1:0] : '0;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      case (style_q[i])
        3'd0:    hit[i] = sy2_q[i];
        3'd1:    hit[i] = ~sy2_q[i];
        3'd2:    hit[i] = sy2_q[i] & ~prv_q[i];
        3'd3:    hit[i] = ~sy2_q[i] & prv_q[i];
        3'd4:    hit[i] = sy2_q[i] ^ prv_q[i];
        default: hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      prv_q <= '0;
    end else begin
      sy1_q <= pin_in;
      sy2_q <= sy1_q;
      prv_q <= sy2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      clk_q  <= '0;
      dbs_q  <= '0;
      stat_q <= '0;
      for (int i = 0; i < NLINES; i++) style_q[i] <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      if (wr_en && aligned) begin
        case (idx)
          A_OUT: out_q <= wr_data[NLINES-1:0];
          A_DIR: dir_q <= wr_data[NLINES-1:0];
          A_CK:  clk_q <= wr_data;
          A_DB:  dbs_q <= wr_data;
          default: ;
        endcase
        for (int i = 0; i < NLINES; i++) begin
          if ((i < PERWORD && idx == A_SL) || (i >= PERWORD && idx == A_SH))
            style_q[i] <= wr_data[SW*(i%PERWORD) +: SW];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      case (idx)
        A_OUT: rd_data[NLINES-1:0] = out_q;
        A_DIR: rd_data[NLINES-1:0] = dir_q;
        A_IN:  rd_data[NLINES-1:0] = sy2_q;
        A_ST:  rd_data[NLINES-1:0] = stat_q;
        A_CK:  rd_data = clk_q;
        A_DB:  rd_data = dbs_q;
        default: begin
          for (int i = 0; i < NLINES; i++) begin
            if ((i < PERWORD && idx == A_SL) || (i >= PERWORD && idx == A_SH))
              rd_data[SW*(i%PERWORD) +: SW] = style_q[i];
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    // R9
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> stat_q[i]);
    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !hit[i]) |=> !stat_q[i]);
    // R8
    zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr[i]) |=> stat_q[i]);
    // R7
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (style_q[i] > 3'd4) |-> !hit[i]);
  end

  for (genvar j = 0; j < NIRQ; j++) begin : g_irq_chk
    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[j]) |-> $past(hit[j]));
  end
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [12:0] irq_o;

  int checks = 0;
  int errors = 0;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] readback(input logic [4:0] a, input logic [31:0] d);
    case (a)
      5'h00, 5'h04: return {16'h0, d[15:0]};
      5'h10, 5'h14: return {8'h0, d[23:0]};
      default:      return d;
    endcase
  endfunction

  function automatic logic [31:0] style_word(input int k, input logic [2:0] code);
    logic [31:0] w = 32'h00FF_FFFF;
    w[3*k +: 3] = code;
    return w;
  endfunction

  function automatic logic exp_hit(input logic [2:0] code, input logic v0, input logic v1);
    case (code)
      3'd0: return v1;
      3'd1: return !v1;
      3'd2: return !v0 && v1;
      3'd3: return v0 && !v1;
      3'd4: return v0 != v1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic quiet_all();
    wr(5'h10, 32'h00FF_FFFF);
    wr(5'h14, 32'h00FF_FFFF);
    wait_clk(4);
    wr(5'h0C, 32'hFFFF);
  endtask

  task automatic run_case(input string req, input int line, input logic [2:0] code,
                          input logic v0, input logic v1);
    logic [31:0] r;
    logic e;
    e = exp_hit(code, v0, v1);
    @(negedge clk); pin_in[line] = v0;
    wr(line < 8 ? 5'h10 : 5'h14, style_word(line % 8, code));
    wait_clk(4);
    wr(5'h0C, 32'hFFFF);
    rd(5'h0C, r);
    chk({req, " idle"}, {31'h0, r[line]}, 32'h0);
    @(negedge clk); pin_in[line] = v1;
    wait_clk(4);
    rd(5'h0C, r);
    chk(req, {31'h0, r[line]}, {31'h0, e});
    if (line < 13) chk({"R10 ", req}, {31'h0, irq_o[line]}, {31'h0, e});
    else chk("R10 no output above 12", {19'h0, irq_o}, 32'h0);
    quiet_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, d;
    logic [4:0] a;
    logic [4:0] alist [6];
    alist = '{5'h00, 5'h04, 5'h10, 5'h14, 5'h18, 5'h1C};
    void'($urandom(32'd1234));

    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset values
    rd(5'h00, r); chk("R1 out", r, 32'h0);
    rd(5'h04, r); chk("R1 dir", r, 32'hFFFF);
    rd(5'h0C, r); chk("R1 status", r, 32'h0);
    rd(5'h10, r); chk("R1 style lo", r, 32'h0);
    rd(5'h14, r); chk("R1 style hi", r, 32'h0);
    rd(5'h18, r); chk("R1 clock", r, 32'h0);
    rd(5'h1C, r); chk("R1 debounce", r, 32'h0);
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 irq", {19'h0, irq_o}, 32'h0);

    // R2 R4 random register traffic
    for (int i = 0; i < 40; i++) begin
      a = alist[$urandom_range(5, 0)];
      d = $urandom;
      wr(a, d);
      rd(a, r);
      chk((a == 5'h10 || a == 5'h14) ? "R4 style readback" : "R2 readback", r, readback(a, d));
      if (a == 5'h00) chk("R2 pin_out", {16'h0, pin_out}, {16'h0, d[15:0]});
      if (a == 5'h04) chk("R2 pin_oe", {16'h0, pin_oe}, {16'h0, ~d[15:0]});
    end
    wr(5'h18, 32'h0);
    rd(5'h18, r); chk("R2 clock zero", r, 32'h0);

    // R3 random pin words, two-clock synchronizer
    for (int i = 0; i < 20; i++) begin
      d = $urandom;
      @(negedge clk); pin_in = d[15:0];
      @(negedge clk);
      rd(5'h08, r);
      chk("R3 input", r, {16'h0, d[15:0]});
    end
    wr(5'h08, 32'h0000_5A5A);
    rd(5'h08, r); chk("R3 input write ignored", r, {16'h0, pin_in});

    @(negedge clk); pin_in = '0;
    quiet_all();
    rd(5'h0C, r); chk("R8 cleared all", r, 32'h0);

    // R4 packing: line 9 lands in bits [5:3] of 0x14
    wr(5'h14, 32'hFF00_0000 | (32'd5 << 3));
    rd(5'h14, r); chk("R4 line9 field", r, 32'h0000_0028);
    quiet_all();

    run_case("R5 high", 3, 3'd0, 1'b0, 1'b1);
    run_case("R5 low", 10, 3'd1, 1'b1, 1'b0);
    run_case("R6 rise", 5, 3'd2, 1'b0, 1'b1);
    run_case("R6 rise ignores fall", 5, 3'd2, 1'b1, 1'b0);
    run_case("R6 fall", 12, 3'd3, 1'b1, 1'b0);
    run_case("R6 fall ignores rise", 12, 3'd3, 1'b0, 1'b1);
    run_case("R6 any up", 0, 3'd4, 1'b0, 1'b1);
    run_case("R6 any down", 0, 3'd4, 1'b1, 1'b0);
    run_case("R6 rise line 14", 14, 3'd2, 1'b0, 1'b1);
    for (int c = 5; c < 8; c++) begin
      run_case("R7 reserved up", 7, 3'(c), 1'b0, 1'b1);
      run_case("R7 reserved down", 7, 3'(c), 1'b1, 1'b0);
    end

    // R9 set wins, R5 clear only after inactive
    wr(5'h10, style_word(2, 3'd0));
    @(negedge clk); pin_in[2] = 1'b1;
    wait_clk(4);
    wr(5'h0C, 32'h4);
    rd(5'h0C, r); chk("R9 set beats clear", {31'h0, r[2]}, 32'h1);
    chk("R10 line2 held", {31'h0, irq_o[2]}, 32'h1);
    @(negedge clk); pin_in[2] = 1'b0;
    wait_clk(4);
    wr(5'h0C, 32'h4);
    rd(5'h0C, r); chk("R5 cleared after inactive", {31'h0, r[2]}, 32'h0);
    quiet_all();

    // R8 write zero keeps, write one clears
    wr(5'h14, style_word(3, 3'd2));
    @(negedge clk); pin_in[11] = 1'b1;
    wait_clk(4);
    wr(5'h0C, 32'h0);
    rd(5'h0C, r); chk("R8 zero keeps", {31'h0, r[11]}, 32'h1);
    wr(5'h0C, 32'h800);
    rd(5'h0C, r); chk("R8 one clears", {31'h0, r[11]}, 32'h0);
    chk("R10 line11 low", {31'h0, irq_o[11]}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule